// File: doc/BRIEF.md
# Configuration Register Bank with Nonvolatile Save and Restore

This block holds four 16-bit configuration registers, plus a status register and a command register, on a plain address/data bus. Selected bit fields of the four configuration registers are mirrored in a slow nonvolatile array. The array is modelled as a small word array with a fixed write latency and a fixed read latency. Its contents survive the block's reset, and the factory contents are set when the model is built.

Software saves the live fields by setting a save bit in the command register, and restores them by setting a restore bit. A restore also runs on its own after every reset, so the register defaults come from the array. A controller moves one register per step between the registers and the array. A busy flag covers each operation from start to end. While the flag is set, all bus writes are dropped. Each command bit reads 1 while its operation runs and clears itself when that operation ends.

Top module: `cfg_nvm_regbank`

## Requirements
- R1: The register map is: status D0h, general config D1h, command D3h, position 21h, user word A 25h, user word B 26h. Config, position and the two user words are fully writable and reset to 0000h. A read of any other address returns 0000h.
- R2: A write to D3h with bit 0 set starts a save of the masked fields into the array. Bit 0 of D3h reads 1 during the save and returns to 0 when the save ends.
- R3: A write to D3h with bit 1 set and bit 0 clear starts a restore from the array. Bit 1 of D3h reads 1 during the restore and returns to 0 when it ends. All other bits of D3h read 0.
- R4: Bit 0 of the status register D0h is the busy flag. It reads 1 for the whole of every save and every restore, and 0 otherwise. All other status bits read 0.
- R5: While busy is 1, a bus write to any address has no effect.
- R6: When reset is released, a restore starts at once. Busy reads 1 and D3h reads 0002h until the restore completes.
- R7: Only these fields take part in a save or restore: config bit 13 and bits 4:0 (mask 201Fh), position bits 11:2 (mask 0FFCh), and bits 11:4 of each user word (mask 0FF0h).
- R8: A restore overwrites only the masked fields. The other bits keep the value they held before the restore. After a reset, those bits are 0.
- R9: If bits 0 and 1 are both set in one write to D3h, only the save runs. D3h reads 0001h, and the registers are not restored.
- R10: Each array write takes WR_LAT cycles and each array read takes RD_LAT cycles. A save keeps busy high for at least 4*WR_LAT cycles, and a restore for at least 4*RD_LAT cycles.
- R11: The array's factory contents are config 0014h, position 0800h, user word A 0A50h and user word B 05A0h. The first restore after power-up yields these values.
- R12: The status register is read-only. Writing it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the automatic restore |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Register address for both reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The save and restore paths are driven with all-ones words, all-zero words and mixed patterns. All-ones saved into the array, followed by zeros in the live registers and a restore, shows exactly which bits each mask lets through. All-ones live over an array word with zeros and a pattern shows that unmasked bits are left alone. Writes issued during the power-up restore, during a save and to the status register tell a dropped write apart from a delayed one. A combined save-and-restore command, followed by a second reset, separates save priority from an accidental restore and shows that the array outlives reset.

// File: rtl/cfgnv_pkg.sv
package cfgnv_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;
  localparam int NREG   = 4;
  localparam int IDX_W  = $clog2(NREG);

  localparam logic [ADDR_W-1:0] A_STATUS = 8'hD0;
  localparam logic [ADDR_W-1:0] A_CONFIG = 8'hD1;
  localparam logic [ADDR_W-1:0] A_CMD    = 8'hD3;
  localparam logic [ADDR_W-1:0] A_POS    = 8'h21;
  localparam logic [ADDR_W-1:0] A_USERA  = 8'h25;
  localparam logic [ADDR_W-1:0] A_USERB  = 8'h26;

  localparam int CMD_SAVE_BIT    = 0;
  localparam int CMD_RESTORE_BIT = 1;
  localparam int STAT_BUSY_BIT   = 0;

  typedef enum logic [1:0] {
    S_IDLE,
    S_STORE,
    S_RELOAD,
    S_DONE
  } ctrl_state_e;

  // Slot index 0..3 : config, position, user A, user B
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    slot_addr = A_CONFIG;
      2'd1:    slot_addr = A_POS;
      2'd2:    slot_addr = A_USERA;
      default: slot_addr = A_USERB;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] keep_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    keep_mask = 16'h201F;
      2'd1:    keep_mask = 16'h0FFC;
      default: keep_mask = 16'h0FF0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] factory_word(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    factory_word = 16'h0014;
      2'd1:    factory_word = 16'h0800;
      2'd2:    factory_word = 16'h0A50;
      default: factory_word = 16'h05A0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] merge_fields(input logic [REG_W-1:0] live,
                                                    input logic [REG_W-1:0] saved,
                                                    input logic [REG_W-1:0] mask);
    merge_fields = (live & ~mask) | (saved & mask);
  endfunction

  function automatic logic slot_hit(input logic [ADDR_W-1:0] addr);
    slot_hit = (addr == A_CONFIG) || (addr == A_POS) ||
               (addr == A_USERA)  || (addr == A_USERB);
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] addr);
    case (addr)
      A_POS:   slot_of = 2'd1;
      A_USERA: slot_of = 2'd2;
      A_USERB: slot_of = 2'd3;
      default: slot_of = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfgnv_nvm_array.sv
module cfgnv_nvm_array
  import cfgnv_pkg::*;
#(
  parameter int WR_LAT = 64,
  parameter int RD_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  output logic             done,
  output logic [REG_W-1:0] rdata,
  output logic             active
);
  localparam int MAXL = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
  localparam int CW   = $clog2(MAXL + 1);

  // Nonvolatile contents: no reset, factory values at build time
  logic [REG_W-1:0] mem [NREG] = '{factory_word(2'd0), factory_word(2'd1),
                                   factory_word(2'd2), factory_word(2'd3)};

  logic [CW-1:0]    cnt;
  logic             p_wr;
  logic [IDX_W-1:0] p_idx;
  logic [REG_W-1:0] p_data;
  logic             commit_now;

  assign commit_now = active && (cnt == '0) && p_wr;
  assign rdata      = mem[p_idx];

  always_ff @(posedge clk) begin
    if (commit_now) mem[p_idx] <= p_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      p_wr   <= 1'b0;
      p_idx  <= '0;
      p_data <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active && (wr_req || rd_req)) begin
        active <= 1'b1;
        cnt    <= wr_req ? CW'(WR_LAT - 1) : CW'(RD_LAT - 1);
        p_wr   <= wr_req;
        p_idx  <= idx;
        p_data <= wdata;
      end else if (active) begin
        if (cnt == '0) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgnv_ctrl.sv
module cfgnv_ctrl
  import cfgnv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_store,
  input  logic             start_reload,
  input  logic             nvm_done,
  input  logic [REG_W-1:0] nvm_rdata,
  output logic             nvm_wr_req,
  output logic             nvm_rd_req,
  output logic [IDX_W-1:0] nvm_idx,
  output logic             ld_stb,
  output logic [IDX_W-1:0] ld_idx,
  output logic [REG_W-1:0] ld_data,
  output logic             busy,
  output logic             store_flag,
  output logic             reload_flag,
  output logic             op_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  ctrl_state_e      state;
  logic [IDX_W-1:0] idx;
  logic             waiting;

  assign nvm_wr_req  = (state == S_STORE)  && !waiting;
  assign nvm_rd_req  = (state == S_RELOAD) && !waiting;
  assign nvm_idx     = idx;
  assign ld_stb      = (state == S_RELOAD) && waiting && nvm_done;
  assign ld_idx      = idx;
  assign ld_data     = nvm_rdata;
  assign busy        = (state != S_IDLE);
  assign store_flag  = (state == S_STORE);
  assign reload_flag = (state == S_RELOAD);
  assign op_done     = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_RELOAD;
      idx     <= '0;
      waiting <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          idx     <= '0;
          waiting <= 1'b0;
          if (start_store)       state <= S_STORE;
          else if (start_reload) state <= S_RELOAD;
        end
        S_STORE, S_RELOAD: begin
          if (!waiting) begin
            waiting <= 1'b1;
          end else if (nvm_done) begin
            waiting <= 1'b0;
            if (idx == LAST) state <= S_DONE;
            else             idx   <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgnv_regs.sv
module cfgnv_regs
  import cfgnv_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic                       ld_stb,
  input  logic [IDX_W-1:0]           ld_idx,
  input  logic [REG_W-1:0]           ld_data,
  output logic [NREG-1:0][REG_W-1:0] regs_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic load_me, write_me;
    assign load_me  = ld_stb && (ld_idx == GI);
    assign write_me = wr_en && (addr == slot_addr(GI));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[g] <= '0;
      else if (load_me)  regs_q[g] <= merge_fields(regs_q[g], ld_data, keep_mask(GI));
      else if (write_me) regs_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_nvm_regbank.sv
module cfg_nvm_regbank
  import cfgnv_pkg::*;
#(
  parameter int WR_LAT = 64,
  parameter int RD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  logic                       busy, store_flag, reload_flag, op_done;
  logic                       wr_accept, start_store, start_reload;
  logic                       nvm_wr_req, nvm_rd_req, nvm_done, nvm_active;
  logic [IDX_W-1:0]           nvm_idx, ld_idx;
  logic [REG_W-1:0]           nvm_rdata, nvm_wdata, ld_data;
  logic                       ld_stb;
  logic [NREG-1:0][REG_W-1:0] regs_q;

  assign wr_accept    = bus_wr && !busy;
  assign start_store  = wr_accept && (bus_addr == A_CMD) && bus_wdata[CMD_SAVE_BIT];
  assign start_reload = wr_accept && (bus_addr == A_CMD) && bus_wdata[CMD_RESTORE_BIT]
                        && !bus_wdata[CMD_SAVE_BIT];
  assign nvm_wdata    = regs_q[nvm_idx] & keep_mask(nvm_idx);

  cfgnv_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_store (start_store),
    .start_reload(start_reload),
    .nvm_done    (nvm_done),
    .nvm_rdata   (nvm_rdata),
    .nvm_wr_req  (nvm_wr_req),
    .nvm_rd_req  (nvm_rd_req),
    .nvm_idx     (nvm_idx),
    .ld_stb      (ld_stb),
    .ld_idx      (ld_idx),
    .ld_data     (ld_data),
    .busy        (busy),
    .store_flag  (store_flag),
    .reload_flag (reload_flag),
    .op_done     (op_done)
  );

  cfgnv_nvm_array #(.WR_LAT(WR_LAT), .RD_LAT(RD_LAT)) u_nvm (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_req(nvm_wr_req),
    .rd_req(nvm_rd_req),
    .idx   (nvm_idx),
    .wdata (nvm_wdata),
    .done  (nvm_done),
    .rdata (nvm_rdata),
    .active(nvm_active)
  );

  cfgnv_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_accept),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .ld_stb (ld_stb),
    .ld_idx (ld_idx),
    .ld_data(ld_data),
    .regs_q (regs_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STATUS) begin
      bus_rdata[STAT_BUSY_BIT] = busy;
    end else if (bus_addr == A_CMD) begin
      bus_rdata[CMD_SAVE_BIT]    = store_flag;
      bus_rdata[CMD_RESTORE_BIT] = reload_flag;
    end else if (slot_hit(bus_addr)) begin
      bus_rdata = regs_q[slot_of(bus_addr)];
    end
  end
endmodule

// File: rtl/cfgnv_checker.sv
module cfgnv_checker
  import cfgnv_pkg::*;
#(
  parameter int WR_LAT = 64,
  parameter int RD_LAT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       store_flag,
  input logic                       reload_flag,
  input logic                       ld_stb,
  input logic                       nvm_active,
  input logic [NREG-1:0][REG_W-1:0] regs_q
);
  localparam int MIN_OP = NREG * RD_LAT;

  logic [31:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busy_run <= '0;
    else if (!busy)                 busy_run <= '0;
    else if (busy_run != '1)        busy_run <= busy_run + 1'b1;
  end

  // R5: registers move only through a restore load while busy
  a_r5_busy_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_stb) |=> $stable(regs_q));

  // R4: the array never works outside a busy window
  a_r4_busy_covers_array: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_active |-> busy);

  // R2, R3: both command bits are clear once busy drops
  a_r2_cmd_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!store_flag && !reload_flag));

  // R9: never a save and a restore at once
  a_r9_one_operation: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_flag, reload_flag}));

  // R10: an operation cannot finish faster than four array reads
  a_r10_min_duration: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run >= MIN_OP));
endmodule

bind cfg_nvm_regbank cfgnv_checker #(.WR_LAT(WR_LAT), .RD_LAT(RD_LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .store_flag (store_flag),
  .reload_flag(reload_flag),
  .ld_stb     (ld_stb),
  .nvm_active (nvm_active),
  .regs_q     (regs_q)
);

// File: tb/tb_cfg_nvm_regbank.sv
module tb_cfg_nvm_regbank;
  localparam int WR_LAT = 64;
  localparam int RD_LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  // bench-side model of the array and masks (from R7, R11)
  logic [15:0] nvm_m [4] = '{16'h0014, 16'h0800, 16'h0A50, 16'h05A0};
  logic [15:0] msk   [4] = '{16'h201F, 16'h0FFC, 16'h0FF0, 16'h0FF0};
  logic [7:0]  adr   [4] = '{8'hD1, 8'h21, 8'h25, 8'h26};

  always #10 clk = ~clk;

  cfg_nvm_regbank #(.WR_LAT(WR_LAT), .RD_LAT(RD_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] s;
    n = 0;
    rd(8'hD0, s);
    while (s[0] && n < 20000) begin
      @(negedge clk);
      n++;
      rd(8'hD0, s);
    end
  endtask

  function automatic logic [15:0] mrg(input logic [15:0] live, sv, m);
    return (live & ~m) | (sv & m);
  endfunction

  task automatic t_power_up();
    logic [15:0] d; int n;
    rd(8'hD0, d); check("R6 busy after reset", d, 16'h0001);
    rd(8'hD3, d); check("R6 restore bit after reset", d, 16'h0002);
    wr(8'hD1, 16'hFFFF);                       // R5: dropped while busy
    wait_idle(n);
    check("R10 restore duration", 16'(n >= 4 * RD_LAT - 2), 16'h0001);
    rd(8'hD3, d); check("R3 restore bit cleared", d, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      rd(adr[i], d); check("R11 factory value (R5 write dropped)", d, nvm_m[i]);
    end
  endtask

  task automatic t_bus_access();
    logic [15:0] d;
    wr(8'hD1, 16'hABCD); rd(8'hD1, d); check("R1 config rw", d, 16'hABCD);
    wr(8'h21, 16'h1234); rd(8'h21, d); check("R1 position rw", d, 16'h1234);
    wr(8'h25, 16'hFFFF); rd(8'h25, d); check("R1 user A rw", d, 16'hFFFF);
    wr(8'h26, 16'h0000); rd(8'h26, d); check("R1 user B rw", d, 16'h0000);
    wr(8'h22, 16'h5555); rd(8'h22, d); check("R1 unmapped reads 0", d, 16'h0000);
    wr(8'hD0, 16'hFFFF); rd(8'hD0, d); check("R12 status read-only", d, 16'h0000);
    wr(8'hD3, 16'hFFFC); rd(8'hD3, d); check("R3 other cmd bits no op", d, 16'h0000);
    rd(8'hD0, d); check("R4 idle busy low", d, 16'h0000);
  endtask

  task automatic t_save();
    logic [15:0] d; int n;
    logic [15:0] v [4] = '{16'h3FFF, 16'hFFFF, 16'h1234, 16'hFFFF};
    for (int i = 0; i < 4; i++) wr(adr[i], v[i]);
    wr(8'hD3, 16'h0001);
    rd(8'hD0, d); check("R4 busy during save", d, 16'h0001);
    rd(8'hD3, d); check("R2 save bit set", d, 16'h0001);
    wr(8'h21, 16'h0000);
    wait_idle(n);
    check("R10 save duration", 16'(n >= 4 * WR_LAT - 2), 16'h0001);
    rd(8'hD3, d); check("R2 save bit cleared", d, 16'h0000);
    rd(8'h21, d); check("R5 write during save dropped", d, 16'hFFFF);
    for (int i = 0; i < 4; i++) nvm_m[i] = v[i] & msk[i];
  endtask

  task automatic t_restore();
    logic [15:0] d; int n;
    logic [15:0] v [4] = '{16'h0000, 16'h0000, 16'hFFFF, 16'h0000};
    for (int i = 0; i < 4; i++) wr(adr[i], v[i]);
    wr(8'hD3, 16'h0002);
    rd(8'hD3, d); check("R3 restore bit set", d, 16'h0002);
    wait_idle(n);
    for (int i = 0; i < 4; i++) begin
      rd(adr[i], d); check("R7 R8 restored fields", d, mrg(v[i], nvm_m[i], msk[i]));
    end
  endtask

  task automatic t_both_bits();
    logic [15:0] d; int n;
    logic [15:0] v [4] = '{16'hC005, 16'h0AA8, 16'h7070, 16'h0BB0};
    for (int i = 0; i < 4; i++) wr(adr[i], v[i]);
    wr(8'hD3, 16'h0003);
    rd(8'hD3, d); check("R9 save wins", d, 16'h0001);
    wait_idle(n);
    for (int i = 0; i < 4; i++) begin
      rd(adr[i], d); check("R9 no restore", d, v[i]);
      nvm_m[i] = v[i] & msk[i];
    end
  endtask

  task automatic t_second_reset();
    logic [15:0] d; int n;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'hD0, d); check("R6 busy after second reset", d, 16'h0001);
    wait_idle(n);
    for (int i = 0; i < 4; i++) begin
      rd(adr[i], d); check("R8 reset then restore", d, mrg(16'h0000, nvm_m[i], msk[i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_power_up();
    t_bus_access();
    t_save();
    t_restore();
    t_both_bits();
    t_second_reset();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vecs++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule